// File: doc/BRIEF.md
# Next-Instruction-Address Unit

This block holds the program counter of a 32-bit, one-instruction-per-cycle core and works out where the following instruction comes from. In each cycle it looks at the current fetch address, the instruction word and the two source operand values supplied by the register read stage. From these it produces the next address, a flag that marks a change of flow, and, for a call, the return address with its write strobe and destination register index.

Three kinds of redirection are handled. The two compare-and-branch forms add a signed 16-bit word offset to the sequential address. The two absolute jumps splice a 26-bit word index under the top four bits of the sequential address. The register jump takes the whole address from the first operand. Every other instruction word advances the address by four bytes.

The program counter register loads the computed address only in cycles where the step input is high. Reset is asserted asynchronously, released in step with the clock, and returns the counter to zero.

Top module: `npc_unit`

## Requirements
- R1: While reset is applied, and after its release until the first step, `pc_q` reads 0x00000000.
- R2: On a rising clock edge with `step_en` high, `pc_q` takes the value `npc_o` showed before the edge. With `step_en` low it keeps its value.
- R3: An instruction that is none of the five control forms gives `npc_o` = `pc_q`+4 and `taken_o` = 0. This includes opcode 0 (bits 31:26) with a function code (bits 5:0) other than 0x08.
- R4: Opcode 4 compares the `rs_val` and `rt_val` operands. When they are equal, `npc_o` = `pc_q`+4 + (sign-extended bits 15:0 shifted left by 2) and `taken_o` = 1.
- R5: Opcode 5 redirects with the same target arithmetic as R4, but only when the operands differ.
- R6: An opcode-4 or opcode-5 branch whose condition fails gives `npc_o` = `pc_q`+4 and `taken_o` = 0.
- R7: Opcode 2 gives `npc_o` = {(`pc_q`+4)[31:28], bits 25:0, 2'b00} and `taken_o` = 1. The top nibble comes from the sequential address, also when that address has crossed into a new 256 MiB region.
- R8: Opcode 3 redirects like R7 and also raises `link_we_o`, with `link_idx_o` = 31 and `link_data_o` = `pc_q`+4.
- R9: Opcode 0 with function code 0x08 gives `npc_o` = `rs_val` and `taken_o` = 1.
- R10: `link_we_o` is 0 for every instruction other than opcode 3.
- R11: Branch offsets reach the extremes 0x7FFF (+32767 words) and 0x8000 (-32768 words). The target arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Allows the program counter to advance this cycle |
| instr | input | 32 | Instruction word at the current address |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc_q | output | 32 | Current program counter |
| npc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | High when `npc_o` is not the sequential address |
| link_we_o | output | 1 | Return-address write strobe |
| link_idx_o | output | 5 | Register index for the return address |
| link_data_o | output | 32 | Return address value |

## Verification
A call does two things in one cycle: it redirects the address and it produces the return address. The bench places call and plain-jump instructions in the last word of a 256 MiB region. The sequential address there carries into the top nibble, and the redirect must use that carried nibble while the link value shows the same incremented address. Both results are judged in the same sample against values computed in the bench from R7 and R8. A branch at address zero with a negative offset also checks that the redirect and the wrap of the sum agree.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned FUNCT_W  = 6;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned JIDX_W   = 26;
  localparam int unsigned REGIDX_W = 5;

  localparam logic [OPC_W-1:0]   OPC_REGOP = 6'd0;
  localparam logic [OPC_W-1:0]   OPC_JMP   = 6'd2;
  localparam logic [OPC_W-1:0]   OPC_CALL  = 6'd3;
  localparam logic [OPC_W-1:0]   OPC_BREQ  = 6'd4;
  localparam logic [OPC_W-1:0]   OPC_BRNE  = 6'd5;
  localparam logic [FUNCT_W-1:0] FN_REGJMP = 6'h08;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_ABS  = 2'd2,
    FLOW_REG  = 2'd3
  } flow_e;

  typedef struct packed {
    flow_e              flow;
    logic               on_ne;
    logic               link;
    logic [IMM_W-1:0]   imm;
    logic [JIDX_W-1:0]  jidx;
  } ctl_dec_t;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctl_dec_t           dec
);

  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0]   opc;
  logic [FUNCT_W-1:0] fn;

  assign opc = instr[INSTR_W-1:OPC_LSB];
  assign fn  = instr[FUNCT_W-1:0];

  always_comb begin
    dec.flow  = FLOW_SEQ;
    dec.on_ne = 1'b0;
    dec.link  = 1'b0;
    dec.imm   = instr[IMM_W-1:0];
    dec.jidx  = instr[JIDX_W-1:0];
    case (opc)
      OPC_BREQ: begin
        dec.flow = FLOW_BR;
      end
      OPC_BRNE: begin
        dec.flow  = FLOW_BR;
        dec.on_ne = 1'b1;
      end
      OPC_JMP: begin
        dec.flow = FLOW_ABS;
      end
      OPC_CALL: begin
        dec.flow = FLOW_ABS;
        dec.link = 1'b1;
      end
      OPC_REGOP: begin
        if (fn == FN_REGJMP) begin
          dec.flow = FLOW_REG;
        end
      end
      default: begin
        dec.flow = FLOW_SEQ;
      end
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ALIGN_B  = 2,
  parameter int unsigned STEP_B   = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JIDX_W-1:0] jidx,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] br_pc,
  output logic [ADDR_W-1:0] abs_pc
);

  localparam int unsigned SEXT_W   = ADDR_W - IMM_W - ALIGN_B;
  localparam int unsigned REGION_W = ADDR_W - JIDX_W - ALIGN_B;

  logic [ADDR_W-1:0] offs;

  always_comb begin
    seq_pc = pc + ADDR_W'(STEP_B);
  end

  always_comb begin
    offs  = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_B{1'b0}}};
    br_pc = seq_pc + offs;
  end

  always_comb begin
    abs_pc = {seq_pc[ADDR_W-1 -: REGION_W], jidx, {ALIGN_B{1'b0}}};
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  ctl_dec_t          dec,
  input  logic [ADDR_W-1:0] rs_val,
  input  logic [ADDR_W-1:0] rt_val,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] abs_pc,
  output logic [ADDR_W-1:0] npc,
  output logic              taken,
  output logic              link_we
);

  localparam int unsigned REGION_W = ADDR_W - JIDX_W - 2;

  logic same;
  logic cond_ok;

  always_comb begin
    same    = (rs_val == rt_val);
    cond_ok = same ^ dec.on_ne;
  end

  always_comb begin
    npc     = seq_pc;
    taken   = 1'b0;
    link_we = 1'b0;
    case (dec.flow)
      FLOW_BR: begin
        if (cond_ok) begin
          npc   = br_pc;
          taken = 1'b1;
        end
      end
      FLOW_ABS: begin
        npc     = abs_pc;
        taken   = 1'b1;
        link_we = dec.link;
      end
      FLOW_REG: begin
        npc   = rs_val;
        taken = 1'b1;
      end
      default: begin
        npc = seq_pc;
      end
    endcase
  end

  AST_FALLTHRU_SEQ: assert property (@(posedge clk) disable iff (!srst_n)
    !taken |-> (npc == seq_pc)); // R3

  AST_BREQ_NEEDS_EQ: assert property (@(posedge clk) disable iff (!srst_n)
    (dec.flow == FLOW_BR && !dec.on_ne && taken) |-> (rs_val == rt_val)); // R4

  AST_BRNE_NEEDS_NE: assert property (@(posedge clk) disable iff (!srst_n)
    (dec.flow == FLOW_BR && dec.on_ne && taken) |-> (rs_val != rt_val)); // R5

  AST_REGION_KEPT: assert property (@(posedge clk) disable iff (!srst_n)
    (dec.flow == FLOW_ABS) |-> (npc[ADDR_W-1 -: REGION_W] == seq_pc[ADDR_W-1 -: REGION_W] && npc[1:0] == 2'b00)); // R7

  AST_REG_TARGET: assert property (@(posedge clk) disable iff (!srst_n)
    (dec.flow == FLOW_REG) |-> (taken && npc == rs_val)); // R9

  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!srst_n)
    link_we |-> (taken && dec.flow == FLOW_ABS)); // R10

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ALIGN_B   = 2,
  parameter int unsigned RST_STAGE = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [REGIDX_W-1:0] LINK_REG = 5'd31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [ADDR_W-1:0]   rs_val,
  input  logic [ADDR_W-1:0]   rt_val,
  output logic [ADDR_W-1:0]   pc_q,
  output logic [ADDR_W-1:0]   npc_o,
  output logic                taken_o,
  output logic                link_we_o,
  output logic [REGIDX_W-1:0] link_idx_o,
  output logic [ADDR_W-1:0]   link_data_o
);

  localparam int unsigned STEP_B = 1 << ALIGN_B;

  logic              srst_n;
  ctl_dec_t          dec;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] abs_pc;
  logic [ADDR_W-1:0] pc_d;

  npc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  npc_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  npc_target #(.ADDR_W(ADDR_W), .ALIGN_B(ALIGN_B), .STEP_B(STEP_B)) u_tgt (
    .pc     (pc_q),
    .imm    (dec.imm),
    .jidx   (dec.jidx),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .abs_pc (abs_pc)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .clk     (clk),
    .srst_n  (srst_n),
    .dec     (dec),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .seq_pc  (seq_pc),
    .br_pc   (br_pc),
    .abs_pc  (abs_pc),
    .npc     (npc_o),
    .taken   (taken_o),
    .link_we (link_we_o)
  );

  always_comb begin
    pc_d = pc_q;
    if (step_en) begin
      pc_d = npc_o;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_q <= RESET_PC;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign link_idx_o  = LINK_REG;
  assign link_data_o = seq_pc;

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !step_en |=> $stable(pc_q)); // R2

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    step_en |=> (pc_q == $past(npc_o))); // R2

  AST_LINK_FIELDS: assert property (@(posedge clk) disable iff (!srst_n)
    link_we_o |-> (link_idx_o == LINK_REG && link_data_o == pc_q + ADDR_W'(STEP_B))); // R8

endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] pc_q;
  logic [31:0] npc_o;
  logic        taken_o;
  logic        link_we_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  npc_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .instr       (instr),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .pc_q        (pc_q),
    .npc_o       (npc_o),
    .taken_o     (taken_o),
    .link_we_o   (link_we_o),
    .link_idx_o  (link_idx_o),
    .link_data_o (link_data_o)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd16, 5'd17, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  function automatic logic [31:0] enc_r(input logic [5:0] fn);
    return {6'd0, 5'd8, 5'd0, 5'd0, 5'd0, fn};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b, input logic st);
    @(negedge clk);
    instr   = w;
    rs_val  = a;
    rt_val  = b;
    step_en = st;
    #1;
  endtask

  task automatic finish_step();
    @(posedge clk);
  endtask

  task automatic set_pc(input logic [31:0] addr);
    drive(enc_r(6'h08), addr, 32'h0, 1'b1);
    finish_step();
    drive(32'h0, 32'h0, 32'h0, 1'b0);
    chk("R9", "pc after register jump", pc_q, addr);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", pc_q, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "pc after release", pc_q, 32'h0);
  endtask

  task automatic t_hold();
    drive(32'h0, 32'h0, 32'h0, 1'b0);
    chk("R3", "seq npc", npc_o, 32'h4);
    chk("R3", "seq taken", {31'b0, taken_o}, 32'h0);
    chk("R10", "seq link", {31'b0, link_we_o}, 32'h0);
    finish_step();
    drive(32'h0, 32'h0, 32'h0, 1'b0);
    finish_step();
    drive(32'h0, 32'h0, 32'h0, 1'b1);
    chk("R2", "pc held with step low", pc_q, 32'h0);
    finish_step();
    drive(32'h0, 32'h0, 32'h0, 1'b0);
    chk("R2", "pc advanced with step high", pc_q, 32'h4);
  endtask

  task automatic t_breq();
    set_pc(32'h0000_1000);
    drive(enc_i(6'd4, 16'd3), 32'd5, 32'd5, 1'b1);
    chk("R4", "breq target", npc_o, 32'h0000_1010);
    chk("R4", "breq taken", {31'b0, taken_o}, 32'h1);
    chk("R10", "breq link", {31'b0, link_we_o}, 32'h0);
    finish_step();
    drive(enc_i(6'd4, 16'd3), 32'd5, 32'd6, 1'b0);
    chk("R2", "pc after breq", pc_q, 32'h0000_1010);
    chk("R6", "breq fail npc", npc_o, 32'h0000_1014);
    chk("R6", "breq fail taken", {31'b0, taken_o}, 32'h0);
  endtask

  task automatic t_brne();
    set_pc(32'h0000_2000);
    drive(enc_i(6'd5, 16'hFFFF), 32'd1, 32'd2, 1'b0);
    chk("R5", "brne target", npc_o, 32'h0000_2000);
    chk("R5", "brne taken", {31'b0, taken_o}, 32'h1);
    drive(enc_i(6'd5, 16'hFFFF), 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0);
    chk("R6", "brne fail npc", npc_o, 32'h0000_2004);
    chk("R6", "brne fail taken", {31'b0, taken_o}, 32'h0);
  endtask

  task automatic t_extremes();
    set_pc(32'h0010_0000);
    drive(enc_i(6'd4, 16'h7FFF), 32'd0, 32'd0, 1'b0);
    chk("R11", "max forward", npc_o, 32'h0012_0000);
    drive(enc_i(6'd4, 16'h8000), 32'd0, 32'd0, 1'b0);
    chk("R11", "max backward", npc_o, 32'h000E_0004);
    set_pc(32'h0000_0000);
    drive(enc_i(6'd5, 16'hFFFE), 32'd0, 32'd9, 1'b0);
    chk("R11", "wrap below zero", npc_o, 32'hFFFF_FFFC);
    chk("R11", "wrap taken", {31'b0, taken_o}, 32'h1);
  endtask

  task automatic t_jump();
    set_pc(32'h4000_0010);
    drive(enc_j(6'd2, 26'h012_3456), 32'h0, 32'h0, 1'b0);
    chk("R7", "abs target", npc_o, 32'h4048_D158);
    chk("R7", "abs taken", {31'b0, taken_o}, 32'h1);
    chk("R10", "abs link", {31'b0, link_we_o}, 32'h0);
    set_pc(32'h0FFF_FFFC);
    drive(enc_j(6'd2, 26'h000_0010), 32'h0, 32'h0, 1'b1);
    chk("R7", "region from seq addr", npc_o, 32'h1000_0040);
    finish_step();
    drive(32'h0, 32'h0, 32'h0, 1'b0);
    chk("R2", "pc after abs", pc_q, 32'h1000_0040);
  endtask

  task automatic t_call();
    set_pc(32'h0040_0020);
    drive(enc_j(6'd3, 26'h000_0100), 32'h0, 32'h0, 1'b0);
    chk("R8", "call target", npc_o, 32'h0000_0400);
    chk("R8", "call strobe", {31'b0, link_we_o}, 32'h1);
    chk("R8", "call index", {27'b0, link_idx_o}, 32'd31);
    chk("R8", "call data", link_data_o, 32'h0040_0024);
    set_pc(32'h7FFF_FFFC);
    drive(enc_j(6'd3, 26'h3FF_FFFF), 32'h0, 32'h0, 1'b0);
    chk("R8", "call across region target", npc_o, 32'h8FFF_FFFC);
    chk("R8", "call across region data", link_data_o, 32'h8000_0000);
    chk("R8", "call across region strobe", {31'b0, link_we_o}, 32'h1);
  endtask

  task automatic t_regjmp();
    set_pc(32'h0000_3000);
    drive(enc_r(6'h08), 32'hDEAD_BEE0, 32'h0, 1'b0);
    chk("R9", "reg target", npc_o, 32'hDEAD_BEE0);
    chk("R9", "reg taken", {31'b0, taken_o}, 32'h1);
    chk("R10", "reg link", {31'b0, link_we_o}, 32'h0);
    drive(enc_r(6'h20), 32'hDEAD_BEE0, 32'h0, 1'b0);
    chk("R3", "other funct npc", npc_o, 32'h0000_3004);
    chk("R3", "other funct taken", {31'b0, taken_o}, 32'h0);
    drive(enc_i(6'd8, 16'h0004), 32'd0, 32'd0, 1'b0);
    chk("R3", "other opcode npc", npc_o, 32'h0000_3004);
    chk("R10", "other opcode link", {31'b0, link_we_o}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_breq();
    t_brne();
    t_extremes();
    t_jump();
    t_call();
    t_regjmp();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule